// File: doc/BRIEF.md
# Predicated Vector Sign-Extend Unit

This block decodes and executes one predicated vector operation. The operation takes each element of a source vector and sign-extends its low byte, halfword or word to the full element width. Each result goes into the matching element of a destination vector. The instruction word chooses the destination element width and the source sub-width. A predicate input decides, element by element, whether the new value is written or the old destination value is kept. Encodings that do not match, or that pair a sub-width with an element width it cannot fill, are flagged as undefined and leave the destination unchanged.

The vector length `VLEN` is a parameter and must be a multiple of 128 bits. The predicate has one bit per byte of the vector. The unit accepts one operation per cycle on a valid/ready input and returns the result on a valid/ready output through a single register stage. An accepted input appears on the output in the next cycle. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input directly. While stalled, a presented result holds every output bit steady until it is taken.

Top module: `sxt_core`

## Requirements
- R1: The operation is recognised only when all of the following hold: instruction bits 31:24 are 0x04, bits 21:19 are 3'b010, bits 15:13 are 3'b101, and bits 18:16 are 3'b000 (byte source), 3'b010 (halfword source) or 3'b100 (word source). Any other word is undefined.
- R2: The size code sits in bits 23:22. A byte source is undefined when the size code is 0. A halfword source is undefined unless bit 23 is 1. A word source is undefined unless the size code is 3.
- R3: The destination element width is 8 shifted left by the size code. The vector holds VLEN divided by that width elements, and element e occupies bits [e*width +: width].
- R4: For an active element, the output element is the low 8, 16 or 32 bits of the source element, sign-extended to the element width.
- R5: Element e is active when predicate bit e*(width/8) is 1. The other predicate bits have no effect. An inactive element outputs the incoming destination element unchanged.
- R6: For an undefined encoding, `out_result` equals the accepted `in_dst`, `out_undef` is 1 and `out_wen` is 0. For a legal encoding, `out_undef` is 0 and `out_wen` is 1.
- R7: `out_pg` carries instruction bits 12:10, `out_zn` carries bits 9:5 and `out_zd` carries bits 4:0 of the accepted instruction.
- R8: An input is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `out_valid` is 1 in the following cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold.
- R9: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | VLEN | Source vector |
| in_dst | input | VLEN | Current destination vector contents |
| in_pred | input | VLEN/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | VLEN | New destination vector |
| out_undef | output | 1 | Encoding was undefined |
| out_wen | output | 1 | Destination write is required |
| out_pg | output | 3 | Predicate register index |
| out_zn | output | 5 | Source register index |
| out_zd | output | 5 | Destination register index |

## Verification
The bench builds the unit with VLEN = 384, three 128-bit granules. At this length every element count is not a power of two (24, 12 and 6 elements), so lane indexing and predicate-bit selection are exercised away from aligned boundaries. Within a short run the bench sweeps every size and source combination under random, all-set and all-clear predicates. It flips each fixed opcode bit and tries each unused source code. It then runs a random stream with random gaps and back-pressure, which exercises stall and hold behaviour.

// File: rtl/sxt_pkg.sv
package sxt_pkg;

  // Fixed fields of the operation encoding.
  localparam logic [7:0] HDR_TOP = 8'h04;
  localparam logic [2:0] HDR_MID = 3'b010;
  localparam logic [2:0] HDR_LOW = 3'b101;

  // Source sub-width selector.
  typedef enum logic [1:0] {
    SRC_B = 2'd0,
    SRC_H = 2'd1,
    SRC_W = 2'd2
  } src_w_e;

  // Decoded view of one instruction word.
  typedef struct packed {
    logic       legal;
    logic [1:0] size;
    src_w_e     src;
    logic [2:0] pg;
    logic [4:0] zn;
    logic [4:0] zd;
  } sxt_dec_t;

  // Side information carried alongside the result.
  typedef struct packed {
    logic       legal;
    logic [2:0] pg;
    logic [4:0] zn;
    logic [4:0] zd;
  } sxt_tag_t;

endpackage

// File: rtl/sxt_decode.sv
module sxt_decode
  import sxt_pkg::*;
(
  input  logic [31:0] insn,
  output sxt_dec_t    dec
);

  logic       hdr_ok;
  logic       var_ok;
  logic       size_ok;
  logic [1:0] size;
  src_w_e     src;

  assign size   = insn[23:22];
  assign hdr_ok = (insn[31:24] == HDR_TOP) &&
                  (insn[21:19] == HDR_MID) &&
                  (insn[15:13] == HDR_LOW);

  always_comb begin
    var_ok  = 1'b1;
    size_ok = 1'b0;
    src     = SRC_B;
    unique case (insn[18:16])
      3'b000: begin src = SRC_B; size_ok = (size != 2'd0); end
      3'b010: begin src = SRC_H; size_ok = size[1];        end
      3'b100: begin src = SRC_W; size_ok = (size == 2'd3); end
      default: var_ok = 1'b0;
    endcase
  end

  assign dec.legal = hdr_ok && var_ok && size_ok;
  assign dec.size  = size;
  assign dec.src   = src;
  assign dec.pg    = insn[12:10];
  assign dec.zn    = insn[9:5];
  assign dec.zd    = insn[4:0];

endmodule

// File: rtl/sxt_lane_array.sv
module sxt_lane_array
  import sxt_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int EW   = 64,
  localparam int NE  = VLEN / EW
) (
  input  src_w_e            sel,
  input  logic [VLEN-1:0]   src,
  input  logic [VLEN-1:0]   dst,
  input  logic [NE-1:0]     pact,
  output logic [VLEN-1:0]   res
);

  // Sub-widths clipped to the element width so narrow lanes stay legal.
  localparam int SH = (EW < 16) ? EW : 16;
  localparam int SW = (EW < 32) ? EW : 32;

  for (genvar e = 0; e < NE; e++) begin : g_lane
    localparam int LO = e * EW;
    logic [EW-1:0] el;
    logic [EW-1:0] ext;
    logic          unused_el;

    assign el        = src[LO +: EW];
    assign unused_el = ^el;

    always_comb begin
      unique case (sel)
        SRC_B:   ext = EW'(signed'(el[7:0]));
        SRC_H:   ext = EW'(signed'(el[SH-1:0]));
        default: ext = EW'(signed'(el[SW-1:0]));
      endcase
    end

    assign res[LO +: EW] = pact[e] ? ext : dst[LO +: EW];
  end

endmodule

// File: rtl/sxt_out_stage.sv
module sxt_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sxt_core.sv
module sxt_core
  import sxt_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int NB  = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [VLEN-1:0] in_src,
  input  logic [VLEN-1:0] in_dst,
  input  logic [NB-1:0]   in_pred,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_result,
  output logic            out_undef,
  output logic            out_wen,
  output logic [2:0]      out_pg,
  output logic [4:0]      out_zn,
  output logic [4:0]      out_zd
);

  localparam int TW = $bits(sxt_tag_t);
  localparam int PW = VLEN + TW;

  sxt_dec_t        dec;
  logic            dec_legal;
  logic [VLEN-1:0] lane_res [4];
  logic [VLEN-1:0] exec_res;
  sxt_tag_t        tag_in;
  sxt_tag_t        tag_out;
  logic [PW-1:0]   pay_in;
  logic [PW-1:0]   pay_out;
  logic            unused_pred;

  sxt_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  assign dec_legal   = dec.legal;
  assign unused_pred = ^in_pred;

  // Byte-wide elements never have a legal encoding: pass the old value.
  assign lane_res[0] = in_dst;

  for (genvar gi = 1; gi < 4; gi++) begin : g_width
    localparam int EW   = 8 << gi;
    localparam int NE   = VLEN / EW;
    localparam int STEP = EW / 8;
    logic [NE-1:0] pact;

    for (genvar e = 0; e < NE; e++) begin : g_pick
      assign pact[e] = in_pred[e * STEP];
    end

    sxt_lane_array #(
      .VLEN (VLEN),
      .EW   (EW)
    ) u_lanes (
      .sel  (dec.src),
      .src  (in_src),
      .dst  (in_dst),
      .pact (pact),
      .res  (lane_res[gi])
    );
  end

  assign exec_res = dec.legal ? lane_res[dec.size] : in_dst;

  assign tag_in.legal = dec.legal;
  assign tag_in.pg    = dec.pg;
  assign tag_in.zn    = dec.zn;
  assign tag_in.zd    = dec.zd;
  assign pay_in       = {exec_res, tag_in};

  sxt_out_stage #(
    .W (PW)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign tag_out    = pay_out[TW-1:0];
  assign out_result = pay_out[PW-1:TW];
  assign out_undef  = !tag_out.legal;
  assign out_wen    = tag_out.legal;
  assign out_pg     = tag_out.pg;
  assign out_zn     = tag_out.zn;
  assign out_zd     = tag_out.zd;

endmodule

// File: rtl/sxt_core_chk.sv
module sxt_core_chk #(
  parameter int VLEN = 256,
  localparam int NB  = VLEN / 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VLEN-1:0] in_dst,
  input logic [NB-1:0]   in_pred,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_result,
  input logic            out_undef,
  input logic            dec_legal
);

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_undef)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  undef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !dec_legal) |=> (out_undef && out_result == $past(in_dst)));

  // R5
  no_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pred == '0) |=> (out_result == $past(in_dst)));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind sxt_core sxt_core_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/sxt_core_tb.sv
module sxt_core_tb;

  localparam int VL = 384;
  localparam int NB = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_insn = '0;
  logic [VL-1:0] in_src = '0;
  logic [VL-1:0] in_dst = '0;
  logic [NB-1:0] in_pred = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VL-1:0] out_result;
  logic          out_undef;
  logic          out_wen;
  logic [2:0]    out_pg;
  logic [4:0]    out_zn;
  logic [4:0]    out_zd;

  sxt_core #(.VLEN(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_src(in_src), .in_dst(in_dst), .in_pred(in_pred),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_undef(out_undef), .out_wen(out_wen), .out_pg(out_pg),
    .out_zn(out_zn), .out_zd(out_zd)
  );

  always #2ns clk = ~clk;

  int checks = 0;
  int failures = 0;

  // Expected contents of the output register.
  bit            exp_v = 1'b0;
  logic [VL-1:0] exp_res;
  bit            exp_legal;
  logic [12:0]   exp_idx;
  string         exp_tag_res;
  string         exp_tag_und;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] rvec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] vr,
                                     input logic [2:0] pg, input logic [4:0] zn,
                                     input logic [4:0] zd);
    return {8'h04, sz, 3'b010, vr, 3'b101, pg, zn, zd};
  endfunction

  // Behavioural reference of one operation.
  task automatic ref_exec(input logic [31:0] insn, input logic [VL-1:0] s,
                          input logic [VL-1:0] d, input logic [NB-1:0] p,
                          output logic [VL-1:0] r, output bit legal,
                          output string tres, output string tund);
    int  sz, esize, sw;
    bit  match, any;
    sz    = int'(insn[23:22]);
    esize = 8 << sz;
    match = insn[31:24] == 8'h04 && insn[21:19] == 3'b010 && insn[15:13] == 3'b101 &&
            (insn[18:16] == 3'b000 || insn[18:16] == 3'b010 || insn[18:16] == 3'b100);
    sw    = (insn[18:16] == 3'b000) ? 8 : (insn[18:16] == 3'b010) ? 16 : 32;
    legal = match && (sw < esize);
    tund  = match ? "R2" : "R1";
    r     = d;
    any   = 1'b0;
    if (legal) begin
      for (int e = 0; e < VL / esize; e++) begin
        if (p[e * (esize / 8)]) begin
          any = 1'b1;
          for (int b = 0; b < esize; b++)
            r[e*esize + b] = (b < sw) ? s[e*esize + b] : s[e*esize + sw - 1];
        end
      end
    end
    tres = !legal ? "R6" : (any ? "R3 R4 R5" : "R5");
  endtask

  // One cycle: check outputs, drive new inputs, advance the model.
  task automatic step(input bit v, input logic [31:0] insn, input int pmode, input bit rdy);
    bit was_v;
    if (out_valid !== exp_v) chk(1'b0, "R8", "out_valid", VL'(out_valid), VL'(exp_v));
    else chk(1'b1, "R8", "out_valid", '0, '0);
    if (exp_v && out_valid) begin
      chk(out_result === exp_res, exp_tag_res, "out_result", out_result, exp_res);
      chk(out_undef === !exp_legal, exp_tag_und, "out_undef", VL'(out_undef), VL'(!exp_legal));
      chk(out_wen === exp_legal, "R6", "out_wen", VL'(out_wen), VL'(exp_legal));
      chk({out_pg, out_zn, out_zd} === exp_idx, "R7", "indices",
          VL'({out_pg, out_zn, out_zd}), VL'(exp_idx));
    end
    in_valid  = v;
    in_insn   = insn;
    in_src    = rvec();
    in_dst    = rvec();
    in_pred   = (pmode == 0) ? rvec()[NB-1:0] : (pmode == 1) ? '1 : '0;
    out_ready = rdy;
    was_v     = exp_v;
    if (v && (!exp_v || rdy)) begin
      ref_exec(insn, in_src, in_dst, in_pred, exp_res, exp_legal, exp_tag_res, exp_tag_und);
      exp_idx = insn[12:0];
      exp_v   = 1'b1;
    end else if (exp_v && rdy) begin
      exp_v = 1'b0;
    end
    #1ns;
    chk(in_ready === (!was_v || rdy), "R8", "in_ready", VL'(in_ready), VL'(!was_v || rdy));
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1ms;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int fixpos[14] = '{31, 30, 29, 28, 27, 26, 25, 24, 21, 20, 19, 15, 14, 13};
    logic [2:0] badv[5] = '{3'b001, 3'b011, 3'b101, 3'b110, 3'b111};
    logic [2:0] goodv[3] = '{3'b000, 3'b010, 3'b100};
    repeat (3) @(negedge clk);
    // R9: idle after reset, ready while empty
    chk(out_valid === 1'b0, "R9", "out_valid in reset", VL'(out_valid), '0);
    chk(in_ready === 1'b1, "R9", "in_ready in reset", VL'(in_ready), VL'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid after reset", VL'(out_valid), '0);

    // R2 R3 R4 R5: every size and source, random / all-set / all-clear predicate
    for (int pm = 0; pm < 3; pm++)
      for (int vi = 0; vi < 3; vi++)
        for (int sz = 0; sz < 4; sz++)
          step(1'b1, mk(2'(sz), goodv[vi], 3'($urandom), 5'($urandom), 5'($urandom)), pm, 1'b1);

    // R1: each fixed bit flipped, and each unused source code
    for (int k = 0; k < 14; k++)
      step(1'b1, mk(2'd3, 3'b000, 3'd5, 5'd9, 5'd17) ^ (32'd1 << fixpos[k]), 1, 1'b1);
    for (int k = 0; k < 5; k++)
      step(1'b1, mk(2'd3, badv[k], 3'd2, 5'd4, 5'd30), 1, 1'b1);

    // R8: random stream with gaps and back-pressure
    for (int c = 0; c < 600; c++) begin
      logic [31:0] insn;
      if (($urandom % 8) == 0) insn = $urandom;
      else insn = mk(2'($urandom), goodv[$urandom % 3], 3'($urandom), 5'($urandom), 5'($urandom));
      step(($urandom % 4) != 0, insn, ($urandom % 5 == 0) ? 2 : 0, ($urandom % 10) < 7);
    end
    for (int c = 0; c < 4; c++) step(1'b0, '0, 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule